// File: doc/BRIEF.md
# ALU condition code register

This block is the status register of a small 8-bit processor core. It holds four result flags (half carry, negative, zero, carry) and the maskable-interrupt disable bit. Each cycle the core presents the 8-bit ALU result, the carries out of bit 3 and bit 7, and a code naming the class of the instruction just executed. The class decides which flags take new values and which keep their old ones.

Software reaches the register in two ways. Single-flag commands set or clear the carry and the interrupt disable bit. A whole-register restore writes every flag at once, which serves both a pop from the stack and the return from an interrupt. The register value is always visible as a unit so that it can be pushed.

The block also gates interrupts. A maskable request that arrives while interrupts are disabled is held until the disable bit falls. A software trap is taken at once in every case. Taking any interrupt sets the disable bit.

Top module: `ccr_flags`

## Requirements
- R1: `ccr` bits 7, 6 and 5 always read 1. Bit 4 is half carry, bit 3 is interrupt disable, bit 2 is negative, bit 1 is zero and bit 0 is carry.
- R2: While `rst_n` is low and just after it rises, `ccr` equals 8'hE8 and `int_take` is 0.
- R3: Half carry takes `cy3` only when `op_cls` is 1 (add or add with carry). Every other class leaves it unchanged.
- R4: When `op_cls` is 1 (add), 2 (other arithmetic), 3 (logic or data move) or 4 (shift or rotate), negative takes `alu_res[7]` and zero takes (`alu_res` == 0). When `op_cls` is 0 (no operation) or 5 (bit test and branch), both keep their values.
- R5: Carry takes `cy7` when `op_cls` is 1, 2, 4 or 5. It is unchanged for classes 0 and 3.
- R6: `flag_cmd` 1 sets carry, 2 clears carry, 3 sets interrupt disable, 4 clears interrupt disable, and 0 does nothing. A command overrides the class update of the same flag in the same cycle.
- R7: When `rest_en` is 1, bits 4 to 0 of `rest_val` are loaded into bits 4 to 0 of `ccr`. The values of `op_cls` and `flag_cmd` have no effect in that cycle, and bits 7 to 5 of `rest_val` are ignored.
- R8: An `irq_req` strobe is latched as pending on the next edge. `int_take` is 1 in each cycle where a request is pending and interrupt disable is 0. The pending latch clears on the edge where the interrupt is taken. A request that arrives while interrupts are disabled stays pending until they are enabled.
- R9: `trap_req` drives `int_take` high in the same cycle, whatever the interrupt disable bit holds.
- R10: After every edge on which `int_take` was 1, interrupt disable is 1. This overrides both the restore and the commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_cls | input | 3 | Class of the instruction just executed (0 to 5) |
| alu_res | input | 8 | ALU result |
| cy3 | input | 1 | Carry out of bit 3 |
| cy7 | input | 1 | Carry or borrow out of bit 7, or the tested bit for a bit test |
| flag_cmd | input | 3 | Single-flag command (0 to 4) |
| rest_en | input | 1 | Whole-register restore strobe (pop, interrupt return) |
| rest_val | input | 8 | Register image to restore |
| irq_req | input | 1 | Maskable interrupt request strobe |
| trap_req | input | 1 | Software trap strobe |
| ccr | output | 8 | Register value |
| int_take | output | 1 | Interrupt taken this cycle |

## Verification
The flag logic is swept over every result byte with all four carry pairs in each of the six classes. This separates the zero and sign detection from carry selection, and it shows which class may touch which flag. The commands are then combined with class updates that try to write the same flag, and restores are issued together with conflicting commands and operations, which exposes any wrong priority order. Interrupt sequences compare a request made while masked, a request made while enabled, a trap made while masked, and a take that falls in the same cycle as a restore that clears the mask.

// File: rtl/ccr_flags.sv
module ccr_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_cls,
  input  logic [7:0] alu_res,
  input  logic       cy3,
  input  logic       cy7,
  input  logic [2:0] flag_cmd,
  input  logic       rest_en,
  input  logic [7:0] rest_val,
  input  logic       irq_req,
  input  logic       trap_req,
  output logic [7:0] ccr,
  output logic       int_take
);
  localparam logic [2:0] OP_ADD   = 3'd1;
  localparam logic [2:0] OP_ARITH = 3'd2;
  localparam logic [2:0] OP_LOGIC = 3'd3;
  localparam logic [2:0] OP_SHIFT = 3'd4;
  localparam logic [2:0] OP_BTEST = 3'd5;

  localparam logic [2:0] CMD_SETC = 3'd1;
  localparam logic [2:0] CMD_CLRC = 3'd2;
  localparam logic [2:0] CMD_SETI = 3'd3;
  localparam logic [2:0] CMD_CLRI = 3'd4;

  logic hc, msk, neg, zer, cry, pend;

  wire wr_h  = (op_cls == OP_ADD);
  wire wr_nz = (op_cls == OP_ADD) || (op_cls == OP_ARITH) ||
               (op_cls == OP_LOGIC) || (op_cls == OP_SHIFT);
  wire wr_c  = (op_cls == OP_ADD) || (op_cls == OP_ARITH) ||
               (op_cls == OP_SHIFT) || (op_cls == OP_BTEST);

  assign int_take = trap_req | (pend & ~msk);
  assign ccr = {3'b111, hc, msk, neg, zer, cry};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc   <= 1'b0;
      msk  <= 1'b1;
      neg  <= 1'b0;
      zer  <= 1'b0;
      cry  <= 1'b0;
      pend <= 1'b0;
    end else begin
      pend <= irq_req | (pend & ~int_take);
      if (rest_en) begin
        {hc, msk, neg, zer, cry} <= rest_val[4:0];
      end else begin
        if (wr_h) hc <= cy3;
        if (wr_nz) begin
          neg <= alu_res[7];
          zer <= (alu_res == 8'd0);
        end
        case (flag_cmd)
          CMD_SETC: cry <= 1'b1;
          CMD_CLRC: cry <= 1'b0;
          default:  if (wr_c) cry <= cy7;
        endcase
        case (flag_cmd)
          CMD_SETI: msk <= 1'b1;
          CMD_CLRI: msk <= 1'b0;
          default:  ;
        endcase
      end
      if (int_take) msk <= 1'b1;
    end
  end
endmodule

// File: rtl/ccr_flags_chk.sv
module ccr_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op_cls,
  input logic [7:0] alu_res,
  input logic       cy3,
  input logic       cy7,
  input logic [2:0] flag_cmd,
  input logic       rest_en,
  input logic [7:0] rest_val,
  input logic       irq_req,
  input logic       trap_req,
  input logic [7:0] ccr,
  input logic       int_take
);
  assert_top_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ccr[7:5] == 3'b111);

  assert_h_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls != 3'd1 && !rest_en) |=> $stable(ccr[4]));

  assert_sign_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls >= 3'd1 && op_cls <= 3'd4 && !rest_en) |=> ccr[2] == $past(alu_res[7]));

  assert_carry_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_cls == 3'd1 || op_cls == 3'd2 || op_cls == 3'd4 || op_cls == 3'd5) &&
     flag_cmd != 3'd1 && flag_cmd != 3'd2 && !rest_en) |=> ccr[0] == $past(cy7));

  assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_en && !int_take) |=> ccr[4:0] == $past(rest_val[4:0]));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |=> (!int_take || trap_req));

  assert_trap_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> int_take);

  assert_take_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |=> ccr[3]);
endmodule

bind ccr_flags ccr_flags_chk u_chk (.*);

// File: tb/sim_ccr_flags.sv
`timescale 1ns/1ps
module sim_ccr_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op_cls = '0, flag_cmd = '0;
  logic [7:0] alu_res = '0, rest_val = '0;
  logic cy3 = 0, cy7 = 0, rest_en = 0, irq_req = 0, trap_req = 0;
  logic [7:0] ccr;
  logic int_take;

  int total = 0, bad = 0;
  bit mH = 0, mI = 1, mN = 0, mZ = 0, mC = 0, mP = 0;

  always #2.5 clk = ~clk;

  ccr_flags u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tg);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tg, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [2:0] o, input logic [7:0] r, input bit c3, input bit c7,
                     input logic [2:0] cmd, input bit le, input logic [7:0] lv,
                     input bit irq, input bit trp, input string tg);
    bit tk;
    @(negedge clk);
    op_cls = o; alu_res = r; cy3 = c3; cy7 = c7; flag_cmd = cmd;
    rest_en = le; rest_val = lv; irq_req = irq; trap_req = trp;
    #1;
    tk = trp | (mP & ~mI);
    chk({7'd0, int_take}, {7'd0, tk}, tg);
    mP = irq | (mP & ~tk);
    if (le) {mH, mI, mN, mZ, mC} = lv[4:0];
    else begin
      if (o == 1) mH = c3;
      if (o >= 1 && o <= 4) begin mN = r[7]; mZ = (r == 0); end
      if (o == 1 || o == 2 || o == 4 || o == 5) mC = c7;
      if (cmd == 1) mC = 1; if (cmd == 2) mC = 0;
      if (cmd == 3) mI = 1; if (cmd == 4) mI = 0;
    end
    if (tk) mI = 1;
    @(posedge clk); #1;
    chk(ccr, {3'b111, mH, mI, mN, mZ, mC}, tg);
  endtask

  task automatic idle(input string tg);
    cyc(0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0, tg);
  endtask

  initial begin
    #750000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ccr, 8'hE8, "R2");
    chk({7'd0, int_take}, 8'd0, "R2");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(ccr, 8'hE8, "R2");

    for (int o = 0; o < 6; o++)
      for (int r = 0; r < 256; r++)
        for (int cc = 0; cc < 4; cc++)
          cyc(o[2:0], r[7:0], cc[0], cc[1], 0, 0, 0, 0, 0,
              o == 1 ? "R3" : (o == 3 || o == 0) ? "R4" : "R5");

    for (int o = 0; o < 6; o++)
      for (int cmd = 0; cmd < 5; cmd++)
        for (int cc = 0; cc < 4; cc++)
          cyc(o[2:0], 8'h80, cc[0], cc[1], cmd[2:0], 0, 0, 0, 0, "R6");

    for (int v = 0; v < 256; v += 7)
      cyc(3'd1, 8'h00, 1, 1, 3'd1, 1, v[7:0], 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, 8'h00, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 1, 8'h1F, 0, 0, "R1");

    cyc(0, 0, 0, 0, 3'd3, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    for (int k = 0; k < 4; k++) idle("R8");
    cyc(0, 0, 0, 0, 3'd4, 0, 0, 0, 0, "R8");
    idle("R8");
    idle("R8");
    cyc(0, 0, 0, 0, 3'd4, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    idle("R8");
    idle("R8");

    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    idle("R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R9");
    cyc(0, 0, 0, 0, 3'd4, 0, 0, 0, 0, "R8");
    idle("R8");
    idle("R8");

    cyc(0, 0, 0, 0, 0, 1, 8'h00, 0, 0, "R10");
    cyc(0, 0, 0, 0, 3'd4, 1, 8'h00, 0, 1, "R10");
    cyc(0, 0, 0, 0, 3'd4, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10");
    cyc(0, 0, 0, 0, 0, 1, 8'h00, 0, 0, "R10");
    idle("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule